// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number, the physical frame number it maps to, and the address-space identifier of the process that owns the mapping. A lookup presents a virtual address. The page-number field is compared against every slot at once. The comparison is restricted to slots whose identifier equals the current process identifier, so mappings from several processes can stay resident together.

On a hit, the physical address is the stored frame number followed by the untranslated offset bits. The width of the offset is log2 of the page size. On a miss, the block raises a miss indication. An external page-table walker then fetches the frame from the page table in memory, which costs the extra memory access that a hit avoids, and installs it through the refill port.

Three maintenance operations are provided:
- Refill, which installs one mapping.
- Flush by identifier, which invalidates one process's mappings.
- Flush all, which empties the whole structure in one cycle.

Top module: `tlb_asid_top`

## Requirements
- R1: While reset is high and in the cycle after, every slot is invalid and `rsp_valid` is low. A lookup after reset reports a miss.
- R2: A lookup accepted on a clock edge (`lk_valid` high) produces `rsp_valid` high on the next edge, with exactly one of `rsp_hit` and `rsp_miss` high. When `rsp_valid` is low, both are low.
- R3: On a hit, `rsp_paddr` equals the stored frame number in the upper PFN_W bits and the lookup's low OFF_W address bits below it.
- R4: A slot hits only if it is valid, its page number equals the upper VPN_W bits of `lk_vaddr`, and its identifier equals `cur_asid` at the lookup edge.
- R5: A refill whose identifier and page number match no valid slot is written to the lowest-numbered invalid slot.
- R6: When every slot is valid, a new refill replaces slots in round-robin order. The order starts at slot 0 after reset and advances by one per such replacement.
- R7: A refill whose identifier and page number equal those of a valid slot overwrites that slot in place.
- R8: A flush by identifier invalidates exactly the slots holding that identifier. All other slots keep hitting.
- R9: A global flush invalidates every slot in one cycle and overrides a refill in the same cycle.
- R10: A lookup in the same cycle as a refill sees the contents from before the refill.
- R11: At no time do two valid slots hold the same identifier and page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_asid | input | ASID_W | Identifier of the running process, used by lookups |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; walker must refill |
| rsp_paddr | output | PFN_W+OFF_W | Translated physical address (zero on miss) |
| rf_valid | input | 1 | Refill write strobe |
| rf_asid | input | ASID_W | Identifier of the mapping being installed |
| rf_vpn | input | VPN_W | Page number being installed |
| rf_pfn | input | PFN_W | Frame number being installed |
| fl_asid_valid | input | 1 | Flush-by-identifier strobe |
| fl_asid | input | ASID_W | Identifier to flush |
| fl_all | input | 1 | Global flush strobe |

## Verification
The hardest state to reach from the ports is a full structure with holes at chosen positions. Only in that state can the free-slot-first rule be told apart from the round-robin rule. The stimulus fills every slot, giving two chosen slots a second identifier, and then flushes that identifier. It then issues two refills and shows that every surviving mapping still hits. A third refill then evicts slot 0, which shows where the round-robin order stands. Same-cycle collisions (lookup with refill, refill with global flush) are driven in a single cycle, and the result is checked on the following lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 16;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 8;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_slot_t;

    function automatic logic tag_eq(input tlb_slot_t s,
                                    input logic [ASID_W-1:0] a,
                                    input logic [VPN_W-1:0] v);
        return s.valid && (s.asid == a) && (s.vpn == v);
    endfunction
endpackage

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
    import tlb_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_all,
    input  logic              fl_asid_valid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_slot_t         wr_slot,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [VPN_W-1:0]  rf_vpn,
    output logic [N_ENT-1:0]  lk_match,
    output logic [N_ENT-1:0]  rf_match,
    output logic [N_ENT-1:0]  valid_vec,
    output logic [PFN_W-1:0]  lk_pfn
);
    tlb_slot_t slots [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || fl_all) begin
                slots[i].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                slots[i] <= wr_slot;
            end else if (fl_asid_valid && (slots[i].asid == fl_asid)) begin
                slots[i].valid <= 1'b0;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i].asid <= '0;
                slots[i].vpn  <= '0;
                slots[i].pfn  <= '0;
            end else if (!fl_all && wr_en && (wr_idx == IDX_W'(i))) begin
                slots[i].asid <= wr_slot.asid;
                slots[i].vpn  <= wr_slot.vpn;
                slots[i].pfn  <= wr_slot.pfn;
            end
        end
        assign lk_match[i]  = tag_eq(slots[i], lk_asid, lk_vpn);
        assign rf_match[i]  = tag_eq(slots[i], rf_asid, rf_vpn);
        assign valid_vec[i] = slots[i].valid;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            lk_pfn = lk_pfn | ({PFN_W{lk_match[i]}} & slots[i].pfn);
        end
    end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [N_ENT-1:0] rf_match,
    input  logic [N_ENT-1:0] valid_vec,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;

    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (rf_match[i])   match_idx = IDX_W'(i);
            if (!valid_vec[i]) free_idx  = IDX_W'(i);
        end
        any_match = |rf_match;
        any_free  = ~&valid_vec;
        if (any_match)     victim = match_idx;
        else if (any_free) victim = free_idx;
        else               victim = rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (accept && !any_match && !any_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_asid_top.sv
module tlb_asid_top
    import tlb_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              rf_valid,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic              fl_asid_valid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_all
);
    logic [N_ENT-1:0] lk_match;
    logic [N_ENT-1:0] rf_match;
    logic [N_ENT-1:0] valid_vec;
    logic [PFN_W-1:0] lk_pfn;
    logic [IDX_W-1:0] victim;
    logic             rf_accept;
    tlb_slot_t        wr_slot;
    logic             hit_now;

    assign rf_accept = rf_valid && !fl_all;
    assign wr_slot   = '{valid: 1'b1, asid: rf_asid, vpn: rf_vpn, pfn: rf_pfn};

    tlb_slot_array #(.N_ENT(N_ENT)) u_array (
        .clk(clk), .rst(rst),
        .fl_all(fl_all), .fl_asid_valid(fl_asid_valid), .fl_asid(fl_asid),
        .wr_en(rf_accept), .wr_idx(victim), .wr_slot(wr_slot),
        .lk_asid(cur_asid), .lk_vpn(lk_vaddr[VA_W-1:OFF_W]),
        .rf_asid(rf_asid), .rf_vpn(rf_vpn),
        .lk_match(lk_match), .rf_match(rf_match),
        .valid_vec(valid_vec), .lk_pfn(lk_pfn)
    );

    tlb_victim_sel #(.N_ENT(N_ENT)) u_victim (
        .clk(clk), .rst(rst), .accept(rf_accept),
        .rf_match(rf_match), .valid_vec(valid_vec), .victim(victim)
    );

    assign hit_now = |lk_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit_now;
            rsp_paddr <= (lk_valid && hit_now) ? {lk_pfn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    assign rsp_miss = rsp_valid && !rsp_hit;
endmodule

// File: rtl/tlb_asid_checker.sv
module tlb_asid_checker #(
    parameter int N_ENT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             fl_all,
    input logic [N_ENT-1:0] valid_vec,
    input logic [N_ENT-1:0] lk_match,
    input logic [N_ENT-1:0] rf_match
);
    // R1
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (valid_vec == '0) && !rsp_valid);
    // R2
    a_r2_resp_timing: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));
    // R9
    a_r9_flush_all: assert property (@(posedge clk) disable iff (rst)
        fl_all |=> (valid_vec == '0));
    // R11
    a_r11_single_lookup_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));
    a_r11_single_refill_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rf_match));
endmodule

bind tlb_asid_top tlb_asid_checker #(.N_ENT(N_ENT)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .fl_all(fl_all),
    .valid_vec(valid_vec), .lk_match(lk_match), .rf_match(rf_match)
);

// File: tb/tlb_asid_top_bench.sv
module tlb_asid_top_bench;
    import tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ASID_W-1:0] cur_asid = '0;
    logic              lk_valid = 1'b0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic              rsp_valid, rsp_hit, rsp_miss;
    logic [PA_W-1:0]   rsp_paddr;
    logic              rf_valid = 1'b0;
    logic [ASID_W-1:0] rf_asid = '0;
    logic [VPN_W-1:0]  rf_vpn = '0;
    logic [PFN_W-1:0]  rf_pfn = '0;
    logic              fl_asid_valid = 1'b0;
    logic [ASID_W-1:0] fl_asid = '0;
    logic              fl_all = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    tlb_asid_top u_tlb_asid_top (
        .clk(clk), .rst(rst), .cur_asid(cur_asid), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr), .rf_valid(rf_valid),
        .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
        .fl_asid_valid(fl_asid_valid), .fl_asid(fl_asid), .fl_all(fl_all)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic refill(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                          input logic [PFN_W-1:0] p);
        @(negedge clk);
        rf_valid = 1'b1; rf_asid = a; rf_vpn = v; rf_pfn = p;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic lookup(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                          input logic [OFF_W-1:0] off, output logic hit,
                          output logic [PA_W-1:0] pa);
        @(negedge clk);
        cur_asid = a; lk_valid = 1'b1; lk_vaddr = {v, off};
        @(negedge clk);
        lk_valid = 1'b0;
        check(rsp_valid && (rsp_hit != rsp_miss), "R2", {rsp_valid, rsp_hit, rsp_miss}, 3'b1xx);
        hit = rsp_hit; pa = rsp_paddr;
    endtask

    task automatic expect_hit(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                              input logic [PFN_W-1:0] p, input string req);
        logic h; logic [PA_W-1:0] pa;
        lookup(a, v, 12'h3C5, h, pa);
        check(h && pa == {p, 12'h3C5}, req, pa, {p, 12'h3C5});
    endtask

    task automatic expect_miss(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                               input string req);
        logic h; logic [PA_W-1:0] pa;
        lookup(a, v, 12'h001, h, pa);
        check(!h, req, h, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R1", {rsp_valid, rsp_hit, rsp_miss}, 0);
        @(negedge clk);
        check(!rsp_valid, "R2 idle", rsp_valid, 0);
        expect_miss(8'h01, 20'h12345, "R1");
    endtask

    task automatic t_hit_asid();
        do_reset();
        refill(8'h01, 20'h12345, 16'hABCD);
        expect_hit(8'h01, 20'h12345, 16'hABCD, "R3");
        expect_miss(8'h02, 20'h12345, "R4");
        expect_miss(8'h01, 20'h12346, "R4");
        refill(8'h02, 20'h12345, 16'h1111);
        expect_hit(8'h02, 20'h12345, 16'h1111, "R4");
        expect_hit(8'h01, 20'h12345, 16'hABCD, "R4");
        refill(8'h01, 20'h12345, 16'h2222);
        expect_hit(8'h01, 20'h12345, 16'h2222, "R7");
        expect_hit(8'h02, 20'h12345, 16'h1111, "R7");
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < 8; i++) refill(8'h01, 20'(i), 16'(16'h100 + i));
        for (int i = 0; i < 8; i++) expect_hit(8'h01, 20'(i), 16'(16'h100 + i), "R5");
        refill(8'h01, 20'h50, 16'h0500);
        expect_miss(8'h01, 20'h0, "R6");
        expect_hit(8'h01, 20'h1, 16'h101, "R6");
        expect_hit(8'h01, 20'h50, 16'h0500, "R6");
        refill(8'h01, 20'h51, 16'h0510);
        expect_miss(8'h01, 20'h1, "R6");
        expect_hit(8'h01, 20'h2, 16'h102, "R6");
        expect_hit(8'h01, 20'h50, 16'h0500, "R6");
    endtask

    task automatic t_free_first();
        do_reset();
        for (int i = 0; i < 8; i++)
            refill((i == 2 || i == 5) ? 8'h03 : 8'h01, 20'(i), 16'(16'h200 + i));
        @(negedge clk); fl_asid_valid = 1'b1; fl_asid = 8'h03;
        @(negedge clk); fl_asid_valid = 1'b0;
        expect_miss(8'h03, 20'h2, "R8");
        expect_miss(8'h03, 20'h5, "R8");
        expect_hit(8'h01, 20'h0, 16'h200, "R8");
        refill(8'h01, 20'h60, 16'h0600);
        refill(8'h01, 20'h61, 16'h0610);
        for (int i = 0; i < 8; i++)
            if (i != 2 && i != 5) expect_hit(8'h01, 20'(i), 16'(16'h200 + i), "R5");
        expect_hit(8'h01, 20'h60, 16'h0600, "R5");
        expect_hit(8'h01, 20'h61, 16'h0610, "R5");
        refill(8'h01, 20'h62, 16'h0620);
        expect_miss(8'h01, 20'h0, "R6");
        expect_hit(8'h01, 20'h1, 16'h201, "R6");
    endtask

    task automatic t_flush_all();
        do_reset();
        refill(8'h01, 20'h10, 16'h0010);
        refill(8'h04, 20'h11, 16'h0011);
        @(negedge clk);
        fl_all = 1'b1; rf_valid = 1'b1; rf_asid = 8'h01; rf_vpn = 20'h70; rf_pfn = 16'h0070;
        @(negedge clk);
        fl_all = 1'b0; rf_valid = 1'b0;
        expect_miss(8'h01, 20'h10, "R9");
        expect_miss(8'h04, 20'h11, "R9");
        expect_miss(8'h01, 20'h70, "R9");
    endtask

    task automatic t_same_cycle();
        logic h;
        do_reset();
        @(negedge clk);
        rf_valid = 1'b1; rf_asid = 8'h05; rf_vpn = 20'h80; rf_pfn = 16'h0880;
        cur_asid = 8'h05; lk_valid = 1'b1; lk_vaddr = {20'h80, 12'h010};
        @(negedge clk);
        rf_valid = 1'b0; lk_valid = 1'b0;
        h = rsp_hit;
        check(rsp_valid && !h, "R10", h, 0);
        expect_hit(8'h05, 20'h80, 16'h0880, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_hit_asid();
        t_round_robin();
        t_free_first();
        t_flush_all();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule